// File: doc/BRIEF.md
# Sum-of-Products Logic Fabric with Shared Term Pool

This block is the combinational logic core of a programmable logic cell group. A bank of input signals is expanded into true and complement literals. A configurable AND-array builds product terms from those literals, and an allocator OR-combines the terms into one sum per output cell. The product terms come in two groups. The shared pool can be claimed by any cell, in any quantity, up to the whole pool. Each cell also owns a fixed set of direct terms, and each of those terms either joins the cell's sum or leaves the block on a control output for use by the cell's register or output enable.

Configuration is held in rows, one row per product term, and is written through a parallel row port while the block is in programming mode. A small sequencer owns the mode. It has five states. `ST_BLANK` is the state after reset. `ST_PROG` accepts writes. `ST_CHECK` spends one cycle validating the configuration. `ST_RUN` drives live outputs. `ST_FAULT` is entered when the configuration is invalid.

The transitions are as follows. Raising `prog_en` moves any state to `ST_PROG`. Dropping `prog_en` in `ST_PROG` moves to `ST_CHECK`. From `ST_CHECK`, the sequencer goes to `ST_FAULT` if any pool term is claimed by more than one cell, and to `ST_RUN` otherwise. Apart from the mode, the input-to-sum path has no clock and is purely combinational.

Top module: `sop_fabric`

## Requirements
- R1: Row data is `{claim[NUM_CELL-1:0], mask[2*NUM_IN-1:0]}`. Mask bit 2i selects input i true, and mask bit 2i+1 selects input i inverted. A term is the AND of its selected literals.
- R2: A term whose mask is all zero evaluates to 0.
- R3: Rows 0 to NUM_PT-1 form the pool. A pool row whose claim field has exactly one bit set, at bit c, feeds sum_out[c]. Any number of pool rows, up to all of them, may feed one cell.
- R4: A pool row with a claim field of zero contributes to no output.
- R5: Row NUM_PT + c*NUM_DIR + k is direct term k of cell c. If its claim field is nonzero, the term is ORed into sum_out[c] and ctl_term[c*NUM_DIR+k] reads 0. Otherwise the term appears on ctl_term[c*NUM_DIR+k] and does not touch the sum.
- R6: After reset, live and cfg_err are 0, all outputs are 0, and every row is cleared.
- R7: sum_out and ctl_term are 0 whenever live is 0. live rises two clock edges after prog_en is sampled low in programming mode (one `ST_CHECK` cycle).
- R8: Row writes are accepted only in `ST_PROG`. A write in any other state leaves the configuration unchanged.
- R9: If any pool row has more than one claim bit set when checked, cfg_err goes to 1, live stays 0 and outputs stay 0 until the block is reprogrammed.
- R10: In `ST_RUN`, outputs follow in_bus with no clock edge.
- R11: Raising prog_en returns the block to programming from any state. Rows that are not rewritten keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sequencer and configuration rows |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | Holds the block in programming mode |
| cfg_we | input | 1 | Row write strobe |
| cfg_addr | input | ADDR_W | Row index |
| cfg_data | input | NUM_CELL+2*NUM_IN | Row contents: claim field above the mask |
| in_bus | input | NUM_IN | Logic inputs |
| sum_out | output | NUM_CELL | One sum-of-products per cell |
| ctl_term | output | NUM_CELL*NUM_DIR | Direct terms not routed into a sum |
| live | output | 1 | High in the running state |
| cfg_err | output | 1 | High when the checked configuration has a doubly claimed term |

## Verification
The bench targets the following corner cases:
- **All-pool claim.** Every pool term is claimed by one cell, which catches an allocator that caps the terms per cell.
- **Empty masks.** Terms with empty masks are given a claim, so a design that reads an empty AND as 1 drives its sums stuck high.
- **Doubly claimed terms.** These must raise cfg_err and keep the outputs quiet. A missing check would drive two sums from one term.
- **Writes outside programming.** These are attempted while running. A leaky write enable would make later sums disagree with the held model.
- **Check-cycle latency.** The bench samples live on the `ST_CHECK` cycle, where a design that skips the check would show live one cycle early.
- **Clockless response.** Inputs are changed within a single clock period, so a registered output would lag them.

// File: rtl/sop_pkg.sv
package sop_pkg;
    typedef enum logic [2:0] {
        ST_BLANK = 3'd0,
        ST_PROG  = 3'd1,
        ST_CHECK = 3'd2,
        ST_RUN   = 3'd3,
        ST_FAULT = 3'd4
    } sop_state_e;
endpackage

// File: rtl/sop_seq.sv
module sop_seq
    import sop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prog_en,
    input  logic conflict,
    output logic wr_open,
    output logic live,
    output logic cfg_err
);
    sop_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BLANK;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK: if (prog_en) state_d = ST_PROG;
            ST_PROG:  if (!prog_en) state_d = ST_CHECK;
            ST_CHECK: begin
                if (prog_en)       state_d = ST_PROG;
                else if (conflict) state_d = ST_FAULT;
                else               state_d = ST_RUN;
            end
            ST_RUN:   if (prog_en) state_d = ST_PROG;
            ST_FAULT: if (prog_en) state_d = ST_PROG;
            default:  state_d = ST_BLANK;
        endcase
    end

    // outputs
    always_comb begin
        wr_open = 1'b0;
        live    = 1'b0;
        cfg_err = 1'b0;
        unique case (state_q)
            ST_PROG:  wr_open = 1'b1;
            ST_RUN:   live    = 1'b1;
            ST_FAULT: cfg_err = 1'b1;
            default:  ;
        endcase
    end

    // R7: live only ever follows a check cycle
    a_r7_live_after_check: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(live) |-> ($past(state_q) == ST_CHECK));

    // R11: programming request always wins
    a_r11_prog_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && state_q != ST_PROG) |=> (state_q == ST_PROG));

    // R9: fault only from a check that saw a conflict
    a_r9_fault_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> ($past(state_q) == ST_CHECK && $past(conflict)));
endmodule

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
    parameter int ROWS     = 25,
    parameter int NUM_PT   = 10,
    parameter int LIT_W    = 12,
    parameter int NUM_CELL = 3,
    parameter int ADDR_W   = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_open,
    input  logic                       cfg_we,
    input  logic [ADDR_W-1:0]          cfg_addr,
    input  logic [NUM_CELL+LIT_W-1:0]  cfg_data,
    output logic [ROWS*LIT_W-1:0]      mask_flat,
    output logic [ROWS*NUM_CELL-1:0]   claim_flat,
    output logic                       conflict
);
    localparam int WORD_W = NUM_CELL + LIT_W;

    logic [WORD_W-1:0] rows_q [ROWS];
    logic              addr_ok;

    assign addr_ok = ({1'b0, cfg_addr} < (ADDR_W+1)'(ROWS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) rows_q[r] <= '0;
        end else if (wr_open && cfg_we && addr_ok) begin
            rows_q[cfg_addr] <= cfg_data;
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_unpack
        assign mask_flat[r*LIT_W +: LIT_W]       = rows_q[r][LIT_W-1:0];
        assign claim_flat[r*NUM_CELL +: NUM_CELL] = rows_q[r][WORD_W-1:LIT_W];
    end

    // a pool term claimed by two or more cells is invalid
    always_comb begin
        conflict = 1'b0;
        for (int p = 0; p < NUM_PT; p++) begin
            if ($countones(rows_q[p][WORD_W-1:LIT_W]) > 1) conflict = 1'b1;
        end
    end

    // R8: configuration changes only after a cycle with writes open
    a_r8_locked_rows: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mask_flat) || !$stable(claim_flat)) |-> $past(wr_open));
endmodule

// File: rtl/sop_and_array.sv
module sop_and_array #(
    parameter int NUM_IN = 6,
    parameter int ROWS   = 25,
    parameter int LIT_W  = 2 * NUM_IN
) (
    input  logic [NUM_IN-1:0]     in_bus,
    input  logic [ROWS*LIT_W-1:0] mask_flat,
    output logic [ROWS-1:0]       term
);
    logic [LIT_W-1:0] lits;

    // even literal = true input, odd literal = inverted input
    for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
        assign lits[2*i]   = in_bus[i];
        assign lits[2*i+1] = ~in_bus[i];
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_term
        logic [LIT_W-1:0] m;
        assign m       = mask_flat[r*LIT_W +: LIT_W];
        // empty mask gives 0 so unused rows stay silent
        assign term[r] = (|m) & (&(~m | lits));
    end
endmodule

// File: rtl/sop_alloc.sv
module sop_alloc #(
    parameter int NUM_PT   = 10,
    parameter int NUM_CELL = 3,
    parameter int NUM_DIR  = 5,
    parameter int ROWS     = NUM_PT + NUM_CELL * NUM_DIR
) (
    input  logic [ROWS-1:0]          term,
    input  logic [ROWS*NUM_CELL-1:0] claim_flat,
    input  logic                     live,
    output logic [NUM_CELL-1:0]      sum_out,
    output logic [NUM_CELL*NUM_DIR-1:0] ctl_term
);
    for (genvar c = 0; c < NUM_CELL; c++) begin : g_cell
        logic pool_hit;
        logic dir_hit;

        always_comb begin
            pool_hit = 1'b0;
            for (int p = 0; p < NUM_PT; p++) begin
                if (claim_flat[p*NUM_CELL +: NUM_CELL] == (NUM_CELL'(1) << c))
                    pool_hit = pool_hit | term[p];
            end
        end

        for (genvar k = 0; k < NUM_DIR; k++) begin : g_dir
            localparam int ROW = NUM_PT + c * NUM_DIR + k;
            logic routed;
            assign routed = |claim_flat[ROW*NUM_CELL +: NUM_CELL];
            assign ctl_term[c*NUM_DIR + k] = live & term[ROW] & ~routed;
        end

        always_comb begin
            dir_hit = 1'b0;
            for (int k = 0; k < NUM_DIR; k++) begin
                if (|claim_flat[(NUM_PT + c*NUM_DIR + k)*NUM_CELL +: NUM_CELL])
                    dir_hit = dir_hit | term[NUM_PT + c*NUM_DIR + k];
            end
        end

        assign sum_out[c] = live & (pool_hit | dir_hit);
    end
endmodule

// File: rtl/sop_fabric.sv
module sop_fabric #(
    parameter int NUM_IN   = 6,
    parameter int NUM_PT   = 10,
    parameter int NUM_CELL = 3,
    parameter int NUM_DIR  = 5,
    localparam int LIT_W   = 2 * NUM_IN,
    localparam int ROWS    = NUM_PT + NUM_CELL * NUM_DIR,
    localparam int ADDR_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int WORD_W  = NUM_CELL + LIT_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        prog_en,
    input  logic                        cfg_we,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [WORD_W-1:0]           cfg_data,
    input  logic [NUM_IN-1:0]           in_bus,
    output logic [NUM_CELL-1:0]         sum_out,
    output logic [NUM_CELL*NUM_DIR-1:0] ctl_term,
    output logic                        live,
    output logic                        cfg_err
);
    logic                     wr_open;
    logic                     conflict;
    logic [ROWS*LIT_W-1:0]    mask_flat;
    logic [ROWS*NUM_CELL-1:0] claim_flat;
    logic [ROWS-1:0]          term;

    sop_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_en  (prog_en),
        .conflict (conflict),
        .wr_open  (wr_open),
        .live     (live),
        .cfg_err  (cfg_err)
    );

    sop_cfg_store #(
        .ROWS(ROWS), .NUM_PT(NUM_PT), .LIT_W(LIT_W),
        .NUM_CELL(NUM_CELL), .ADDR_W(ADDR_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_open    (wr_open),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_data   (cfg_data),
        .mask_flat  (mask_flat),
        .claim_flat (claim_flat),
        .conflict   (conflict)
    );

    sop_and_array #(
        .NUM_IN(NUM_IN), .ROWS(ROWS), .LIT_W(LIT_W)
    ) u_and (
        .in_bus    (in_bus),
        .mask_flat (mask_flat),
        .term      (term)
    );

    sop_alloc #(
        .NUM_PT(NUM_PT), .NUM_CELL(NUM_CELL), .NUM_DIR(NUM_DIR), .ROWS(ROWS)
    ) u_alloc (
        .term       (term),
        .claim_flat (claim_flat),
        .live       (live),
        .sum_out    (sum_out),
        .ctl_term   (ctl_term)
    );

    // R9: a faulted block keeps its outputs quiet
    a_r9_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (sum_out == '0 && ctl_term == '0 && !live));
endmodule

// File: tb/test_sop_fabric.sv
module test_sop_fabric;
    localparam int NI = 6;
    localparam int NP = 10;
    localparam int NC = 3;
    localparam int ND = 5;
    localparam int LW = 2 * NI;
    localparam int NR = NP + NC * ND;
    localparam int AW = $clog2(NR);
    localparam int WW = NC + LW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_en = 1'b0;
    logic cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [WW-1:0] cfg_data = '0;
    logic [NI-1:0] in_bus = '0;
    logic [NC-1:0] sum_out;
    logic [NC*ND-1:0] ctl_term;
    logic live, cfg_err;

    int n_cmp = 0;
    int n_bad = 0;
    logic [LW-1:0] m_mask  [NR];
    logic [NC-1:0] m_claim [NR];

    always #4 clk = ~clk;

    sop_fabric #(.NUM_IN(NI), .NUM_PT(NP), .NUM_CELL(NC), .NUM_DIR(ND)) i_sop_fabric (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_bus(in_bus),
        .sum_out(sum_out), .ctl_term(ctl_term), .live(live), .cfg_err(cfg_err)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic term_of(int r, logic [NI-1:0] x);
        logic [LW-1:0] lit;
        for (int i = 0; i < NI; i++) begin
            lit[2*i]   = x[i];
            lit[2*i+1] = ~x[i];
        end
        return (m_mask[r] != '0) && ((m_mask[r] & ~lit) == '0);
    endfunction

    function automatic logic [NC-1:0] exp_sum(logic [NI-1:0] x);
        logic [NC-1:0] s = '0;
        for (int c = 0; c < NC; c++) begin
            for (int p = 0; p < NP; p++)
                if (m_claim[p] == (NC'(1) << c) && term_of(p, x)) s[c] = 1'b1;
            for (int k = 0; k < ND; k++)
                if (m_claim[NP+c*ND+k] != '0 && term_of(NP+c*ND+k, x)) s[c] = 1'b1;
        end
        return s;
    endfunction

    function automatic logic [NC*ND-1:0] exp_ctl(logic [NI-1:0] x);
        logic [NC*ND-1:0] t = '0;
        for (int c = 0; c < NC; c++)
            for (int k = 0; k < ND; k++)
                if (m_claim[NP+c*ND+k] == '0 && term_of(NP+c*ND+k, x)) t[c*ND+k] = 1'b1;
        return t;
    endfunction

    task automatic wr_row(int r, logic [NC-1:0] cl, logic [LW-1:0] mk, bit take);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(r); cfg_data = {cl, mk};
        @(negedge clk);
        cfg_we = 1'b0;
        if (take) begin m_mask[r] = mk; m_claim[r] = cl; end
    endtask

    task automatic enter_prog();
        @(negedge clk); prog_en = 1'b1;
        @(negedge clk);
        chk("R7 quiet in programming", {sum_out, ctl_term, live}, 0);
    endtask

    task automatic leave_prog(logic want_err);
        @(negedge clk); prog_en = 1'b0;
        @(negedge clk);
        chk("R7 live low during check", live, 0);
        @(negedge clk);
        chk("R7/R9 live after check", live, !want_err);
        chk("R9 cfg_err after check", cfg_err, want_err);
    endtask

    task automatic vec(string tag, logic [NI-1:0] x);
        in_bus = x;
        #1;
        chk({tag, " sum"}, sum_out, live ? exp_sum(x) : '0);
        chk({tag, " ctl"}, ctl_term, live ? exp_ctl(x) : '0);
    endtask

    function automatic logic [LW-1:0] sparse_mask();
        return LW'($urandom & $urandom & $urandom);
    endfunction

    function automatic logic [NC-1:0] one_claim();
        int r = int'($urandom % (NC + 1));
        return (r == NC) ? '0 : (NC'(1) << r);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        for (int r = 0; r < NR; r++) begin m_mask[r] = '0; m_claim[r] = '0; end
        #1;
        chk("R6 outputs in reset", {sum_out, ctl_term, live, cfg_err}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 idle after reset", {sum_out, ctl_term, live, cfg_err}, 0);

        // R3: whole pool to cell 1, single-literal masks; R2: empty mask claimed
        enter_prog();
        for (int p = 0; p < NP; p++)
            wr_row(p, NC'(2), (p == NP-1) ? '0 : (LW'(1) << (p % LW)), 1'b1);
        for (int q = NP; q < NR; q++)
            wr_row(q, (q % 2 == 0) ? NC'(1) : '0, sparse_mask(), 1'b1);
        leave_prog(1'b0);
        for (int v = 0; v < (1 << NI); v++) begin
            @(negedge clk);
            vec("R1 R3 R5 full pool", NI'(v));
        end
        // R2: empty-mask term alone claimed by cell 0
        enter_prog();
        for (int p = 0; p < NP; p++) wr_row(p, (p == 0) ? NC'(1) : '0, '0, 1'b1);
        leave_prog(1'b0);
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            vec("R2 empty mask", NI'($urandom));
        end

        // R10: several input changes inside one clock period
        @(negedge clk);
        vec("R10 clockless a", '0);
        vec("R10 clockless b", '1);
        vec("R10 clockless c", NI'(6'h15));

        // R8: write while running is ignored
        wr_row(NP, NC'(1), '1, 1'b0);
        wr_row(0, NC'(1), LW'(1), 1'b0);
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            vec("R8 locked write", NI'($urandom));
        end

        // random configurations; R4 covered by zero claims
        for (int n = 0; n < 6; n++) begin
            enter_prog();
            for (int r = 0; r < NR; r++)
                wr_row(r, (r < NP) ? one_claim() : NC'($urandom % 2), sparse_mask(), 1'b1);
            leave_prog(1'b0);
            for (int v = 0; v < 30; v++) begin
                @(negedge clk);
                vec("R1 R3 R4 R5 random", NI'($urandom));
            end
        end

        // R9: doubly claimed pool term
        enter_prog();
        wr_row(2, NC'(3), LW'(1), 1'b1);
        leave_prog(1'b1);
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            in_bus = NI'($urandom); #1;
            chk("R9 fault quiet", {sum_out, ctl_term}, 0);
        end

        // R11: reprogram one row from fault, others retained
        enter_prog();
        wr_row(2, NC'(4), LW'(1), 1'b1);
        leave_prog(1'b0);
        for (int v = 0; v < 20; v++) begin
            @(negedge clk);
            vec("R11 retained rows", NI'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule